// File: doc/BRIEF.md
# Exception Capture Unit

This unit sits beside the control path of a simple 32-bit RISC core and records exceptions. Control reports two kinds of fault, an unrecognised opcode and a signed add/subtract overflow, and gives the program counter of the faulting instruction with each. In the cycle a fault is reported, the unit sends the fetch stage to a fixed handler address and blocks the register-file write of the faulting instruction. On the following clock edge it stores the faulting PC in an exception-PC register and a code for the kind of fault in a cause register.

Both registers sit in a small system-register space that is addressed by a 5-bit number. A move-from-system-register instruction reads that space combinationally, and the core copies the result into a general-purpose register. The fault requests, the redirect and the write-enable gate are plain control pins. They carry no valid/ready handshake because the core's control path decides in one cycle whether a fault is taken and cannot stall it.

Top module: `excp_unit`

## Requirements
- R1: A synchronous reset clears both the exception-PC register and the cause register to zero. Register numbers 13 (cause) and 14 (exception PC) then read zero.
- R2: When `undef_req` is high at a rising edge, that edge loads `fault_pc` into the exception PC and 0x28 into the cause register.
- R3: When `ovf_req` is high and `undef_req` is low at a rising edge, that edge loads `fault_pc` into the exception PC and 0x30 into the cause register.
- R4: When both requests are high in the same cycle, the undefined-opcode fault wins and the cause becomes 0x28.
- R5: While either request is high, `pc_next_out` equals the handler address (default 0x80000180). Otherwise it equals `pc_next_in`.
- R6: While either request is high, `rf_we_out` is low. Otherwise it follows `rf_we_in`.
- R7: `rd_data` returns the cause register when `rd_sel` is 13 and the exception PC when `rd_sel` is 14. Every other register number reads zero.
- R8: At an edge with no request, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| undef_req | input | 1 | Current instruction has an unrecognised opcode |
| ovf_req | input | 1 | Current add/subtract overflowed |
| fault_pc | input | 32 | PC of the current instruction |
| pc_next_in | input | 32 | Next PC chosen by normal control |
| pc_next_out | output | 32 | Next PC after the exception redirect |
| rf_we_in | input | 1 | Register-file write enable from control |
| rf_we_out | output | 1 | Write enable after the fault gate |
| rd_sel | input | 5 | System register number to read |
| rd_data | output | 32 | Selected system register value |

## Verification
The case that is hardest to reach from the ports is a simultaneous request on both fault lines that comes right after a different fault. In that case the priority decision shows up only as a cause code that differs from the stored one. The stimulus table therefore places an overflow just before a double request, so that a wrong priority leaves 0x30 in place where 0x28 is expected. The table also includes cycles with no request between faults, which shows that the stored values hold while the PC and write-enable inputs keep changing.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int unsigned XLEN_D       = 32;
  localparam int unsigned SEL_W_D      = 5;
  localparam int unsigned CAUSE_NUM_D  = 13;
  localparam int unsigned EPC_NUM_D    = 14;
  localparam logic [7:0]  CODE_UNDEF   = 8'h28;
  localparam logic [7:0]  CODE_OVF     = 8'h30;

  typedef enum logic [1:0] {
    FAULT_NONE  = 2'd0,
    FAULT_UNDEF = 2'd1,
    FAULT_OVF   = 2'd2
  } fault_e;
endpackage

// File: rtl/excp_arbiter.sv
module excp_arbiter
  import excp_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_D
) (
  input  logic            undef_req,
  input  logic            ovf_req,
  output logic            take,
  output logic [XLEN-1:0] code
);
  fault_e kind;

  // Undefined opcode outranks overflow.
  always_comb begin
    if (undef_req)    kind = FAULT_UNDEF;
    else if (ovf_req) kind = FAULT_OVF;
    else              kind = FAULT_NONE;
  end

  always_comb begin
    take = (kind != FAULT_NONE);
    unique case (kind)
      FAULT_UNDEF: code = XLEN'(CODE_UNDEF);
      FAULT_OVF:   code = XLEN'(CODE_OVF);
      default:     code = '0;
    endcase
  end
endmodule

// File: rtl/excp_regs.sv
module excp_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [XLEN-1:0] code,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= pc;
      cause_q <= code;
    end
  end
endmodule

// File: rtl/excp_readmux.sv
module excp_readmux #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned CAUSE_NUM = 13,
  parameter int unsigned EPC_NUM   = 14
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  epc_q,
  input  logic [XLEN-1:0]  cause_q,
  output logic [XLEN-1:0]  data
);
  localparam int unsigned NREG = 1 << SEL_W;

  logic [XLEN-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i == CAUSE_NUM) begin : g_cause
      assign bank[i] = cause_q;
    end else if (i == EPC_NUM) begin : g_epc
      assign bank[i] = epc_q;
    end else begin : g_zero
      assign bank[i] = '0;
    end
  end

  assign data = bank[sel];
endmodule

// File: rtl/excp_unit.sv
module excp_unit
  import excp_pkg::*;
#(
  parameter int unsigned     XLEN      = XLEN_D,
  parameter int unsigned     SEL_W     = SEL_W_D,
  parameter int unsigned     CAUSE_NUM = CAUSE_NUM_D,
  parameter int unsigned     EPC_NUM   = EPC_NUM_D,
  parameter logic [XLEN-1:0] HANDLER   = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             undef_req,
  input  logic             ovf_req,
  input  logic [XLEN-1:0]  fault_pc,
  input  logic [XLEN-1:0]  pc_next_in,
  output logic [XLEN-1:0]  pc_next_out,
  input  logic             rf_we_in,
  output logic             rf_we_out,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [XLEN-1:0]  rd_data
);
  logic            take;
  logic [XLEN-1:0] code;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] cause_q;

  excp_arbiter #(.XLEN(XLEN)) u_arb (
    .undef_req(undef_req),
    .ovf_req  (ovf_req),
    .take     (take),
    .code     (code)
  );

  excp_regs #(.XLEN(XLEN)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .code   (code),
    .pc     (fault_pc),
    .epc_q  (epc_q),
    .cause_q(cause_q)
  );

  excp_readmux #(
    .XLEN(XLEN), .SEL_W(SEL_W), .CAUSE_NUM(CAUSE_NUM), .EPC_NUM(EPC_NUM)
  ) u_rd (
    .sel    (rd_sel),
    .epc_q  (epc_q),
    .cause_q(cause_q),
    .data   (rd_data)
  );

  assign pc_next_out = take ? HANDLER : pc_next_in;
  assign rf_we_out   = rf_we_in & ~take;
endmodule

// File: rtl/excp_unit_chk.sv
module excp_unit_chk #(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     SEL_W     = 5,
  parameter int unsigned     CAUSE_NUM = 13,
  parameter int unsigned     EPC_NUM   = 14,
  parameter logic [XLEN-1:0] HANDLER   = 32'h8000_0180
) (
  input logic             clk,
  input logic             rst,
  input logic             undef_req,
  input logic             ovf_req,
  input logic [XLEN-1:0]  fault_pc,
  input logic [XLEN-1:0]  pc_next_out,
  input logic             rf_we_out,
  input logic [SEL_W-1:0] rd_sel,
  input logic [XLEN-1:0]  rd_data,
  input logic [XLEN-1:0]  epc_q,
  input logic [XLEN-1:0]  cause_q
);
  // R2 R4
  undef_cause_chk: assert property (@(posedge clk) disable iff (rst)
    undef_req |=> (cause_q == XLEN'(32'h28)) && (epc_q == $past(fault_pc)));

  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_req && !undef_req) |=> (cause_q == XLEN'(32'h30)) && (epc_q == $past(fault_pc)));

  // R5
  handler_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (undef_req || ovf_req) |-> (pc_next_out == HANDLER));

  // R6
  wb_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (undef_req || ovf_req) |-> !rf_we_out);

  // R8
  hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
    !(undef_req || ovf_req) |=> $stable(epc_q) && $stable(cause_q));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel != SEL_W'(CAUSE_NUM) && rd_sel != SEL_W'(EPC_NUM)) |-> (rd_data == '0));
endmodule

bind excp_unit excp_unit_chk #(
  .XLEN(XLEN), .SEL_W(SEL_W), .CAUSE_NUM(CAUSE_NUM), .EPC_NUM(EPC_NUM), .HANDLER(HANDLER)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .undef_req  (undef_req),
  .ovf_req    (ovf_req),
  .fault_pc   (fault_pc),
  .pc_next_out(pc_next_out),
  .rf_we_out  (rf_we_out),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .epc_q      (epc_q),
  .cause_q    (cause_q)
);

// File: tb/tb_excp_unit.sv
module tb_excp_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  typedef struct packed {
    logic        undef;
    logic        ovf;
    logic        we;
    logic [31:0] pc;
    logic [31:0] exp_cause;
    logic [31:0] exp_epc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b1, 32'h0040_0010, 32'h28, 32'h0040_0010},
    '{1'b0, 1'b0, 1'b1, 32'h0040_0020, 32'h28, 32'h0040_0010},
    '{1'b0, 1'b1, 1'b1, 32'h0040_0104, 32'h30, 32'h0040_0104},
    '{1'b1, 1'b1, 1'b1, 32'h1000_0008, 32'h28, 32'h1000_0008},
    '{1'b0, 1'b0, 1'b1, 32'h2000_0000, 32'h28, 32'h1000_0008},
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'h30, 32'hFFFF_FFFC}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        undef_req, ovf_req, rf_we_in;
  logic [31:0] fault_pc, pc_next_in;
  logic [31:0] pc_next_out, rd_data;
  logic        rf_we_out;
  logic [4:0]  rd_sel;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excp_unit dut (
    .clk(clk), .rst(rst), .undef_req(undef_req), .ovf_req(ovf_req),
    .fault_pc(fault_pc), .pc_next_in(pc_next_in), .pc_next_out(pc_next_out),
    .rf_we_in(rf_we_in), .rf_we_out(rf_we_out), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic        taken;
    rst = 1'b1; undef_req = 1'b0; ovf_req = 1'b0; rf_we_in = 1'b0;
    fault_pc = '0; pc_next_in = '0; rd_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    read_reg(5'd13, v); chk("R1 cause after reset", v, 32'h0);
    read_reg(5'd14, v); chk("R1 epc after reset", v, 32'h0);

    // Vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      undef_req  = VECS[i].undef;
      ovf_req    = VECS[i].ovf;
      rf_we_in   = VECS[i].we;
      fault_pc   = VECS[i].pc;
      pc_next_in = VECS[i].pc + 32'd4;
      taken      = VECS[i].undef | VECS[i].ovf;
      #1;
      chk("R5 next pc", pc_next_out, taken ? HANDLER : VECS[i].pc + 32'd4);
      chk("R6 write enable", {31'b0, rf_we_out}, {31'b0, VECS[i].we & ~taken});
      @(negedge clk);
      undef_req = 1'b0; ovf_req = 1'b0;
      read_reg(5'd13, v); chk("R2/R3/R4/R8 cause", v, VECS[i].exp_cause);
      read_reg(5'd14, v); chk("R2/R3/R8 epc", v, VECS[i].exp_epc);
    end

    // R7: unmapped numbers read zero while registers are non-zero
    read_reg(5'd0,  v); chk("R7 sel 0",  v, 32'h0);
    read_reg(5'd12, v); chk("R7 sel 12", v, 32'h0);
    read_reg(5'd15, v); chk("R7 sel 15", v, 32'h0);
    read_reg(5'd31, v); chk("R7 sel 31", v, 32'h0);

    // R6: no fault, write enable high passes through
    rf_we_in = 1'b1; #1;
    chk("R6 passthrough", {31'b0, rf_we_out}, 32'h1);

    // R8: several idle edges keep the last fault
    repeat (4) @(negedge clk);
    fault_pc = 32'h1234_5678;
    @(negedge clk);
    read_reg(5'd14, v); chk("R8 epc idle hold", v, 32'hFFFF_FFFC);

    // R1: reset during operation clears the registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_reg(5'd13, v); chk("R1 cause after mid reset", v, 32'h0);
    read_reg(5'd14, v); chk("R1 epc after mid reset", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule